// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register window through which a host processor hands commands to an embedded power-management controller and collects the answer. The host sees a small memory-mapped space on a simple bus (byte address, write strobe, read strobe, 32-bit data). It can hold a command word, two 32-bit pointers, a 16-byte outbound data area and a 16-byte inbound data area. A status register shows the exchange in progress, the error result and a pending completion interrupt.

The host fills the pointers and the outbound area, then writes the command word. That write starts the exchange. The block marks itself busy and pulses a doorbell towards the controller. The controller reads the decoded command fields, the pointers and the outbound words. It stages its answer into the inbound area one word at a time and finishes with a done strobe carrying an error flag and an 8-bit error code. If the command asked for it, completion raises the host interrupt line, and it stays high until the host acknowledges it.

Top module: `host_ctl_mailbox`

## Requirements
- R1: Registers sit at byte offsets: command 0x00, status 0x04, source pointer 0x08, destination pointer 0x0C, outbound words 0x80/0x84/0x88/0x8C, inbound words 0x90/0x94/0x98/0x9C. The command, pointer and outbound registers read back what was last written. Any other address reads as zero, and nothing is driven when the read strobe is low.
- R2: A command write while idle stores the word and sets status bit 0 (busy), visible from the next cycle. In that same next cycle it gives a one-cycle doorbell pulse and clears status bit 1 and the error code.
- R3: The controller sees the stored command split into fields: operation code in bits 7:0, completion-interrupt request in bit 8, subcommand in bits 15:12 and input length in bytes in bits 20:16.
- R4: A command write while busy is ignored. The stored word does not change and no doorbell pulse follows.
- R5: While busy, host writes to the pointer registers and the outbound words are ignored.
- R6: Controller writes to the inbound area go to a staging copy. Host reads return the data of the last completed exchange, including while busy. Staged data becomes visible on an accepted done strobe.
- R7: A done strobe while busy clears busy and loads status bit 1 with the error flag. When the flag is set it loads status bits 23:16 with the error code (0 none, 1 not supported, 2 not serviced, 3 unable to service, 4 invalid, 5 failed, 6 security reject, 7 unsigned image). Otherwise the code reads 0.
- R8: A done strobe while idle has no effect on status or the inbound area.
- R9: Completion of a command with bit 8 set sets status bit 2. The host interrupt output follows that bit. Writing 1 to status bit 2 clears it, writing 0 leaves it, and host writes cannot change bits 0, 1 or 23:16.
- R10: Reset clears every register, both data areas, all status bits and the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 8 | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt to the host |
| ctl_doorbell | output | 1 | One-cycle pulse: new command accepted |
| ctl_op | output | 8 | Operation code |
| ctl_sub | output | 4 | Subcommand |
| ctl_len | output | 5 | Input length in bytes |
| ctl_irq_req | output | 1 | Command asked for a completion interrupt |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_wbuf | output | 128 | Outbound words, word 0 in the low bits |
| ctl_rb_we | input | 1 | Controller writes one staged inbound word |
| ctl_rb_idx | input | 2 | Inbound word index |
| ctl_rb_data | input | 32 | Inbound word data |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Completion error flag |
| ctl_err_code | input | 8 | Completion error code |

## Verification
The bench builds the block with its default parameters: four buffer words, an 8-bit error code, a 4-bit subcommand and a 5-bit length field. This puts the top word of each data area (0x8C and 0x9C), a full 16-byte length value and the highest error codes within reach. With these values it checks the field split of a command word that has every field non-zero. It also covers busy-time writes of every kind, staging against visible inbound data, idle done strobes, and interrupt acknowledge with a written 1 and with a written 0.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int WORD_W      = 32;
   localparam int OFF_CMD     = 'h00;
   localparam int OFF_STS     = 'h04;
   localparam int OFF_SPTR    = 'h08;
   localparam int OFF_DPTR    = 'h0C;
   localparam int OFF_WBUF    = 'h80;
   localparam int OFF_RBUF    = 'h90;
   localparam int MAX_WORDS   = 4;
   localparam int ST_BUSY     = 0;
   localparam int ST_ERR      = 1;
   localparam int ST_IRQ      = 2;
   localparam int ST_CODE_LSB = 16;
   localparam int CMD_OP_W    = 8;
   localparam int CMD_IRQ_BIT = 8;
   localparam int CMD_SUB_LSB = 12;
   localparam int CMD_LEN_LSB = 16;
endpackage

// File: rtl/mbx_hostregs.sv
module mbx_hostregs
   import mbx_pkg::*;
#(
   parameter int BUF_WORDS = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             h_addr,
   input  logic                          h_wr,
   input  logic [WORD_W-1:0]             h_wdata,
   input  logic                          busy,
   output logic                          cmd_accept,
   output logic                          doorbell,
   output logic [WORD_W-1:0]             cmd_q,
   output logic [WORD_W-1:0]             sptr_q,
   output logic [WORD_W-1:0]             dptr_q,
   output logic [BUF_WORDS*WORD_W-1:0]   wbuf_flat
);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'(OFF_SPTR);
   localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFF_DPTR);

   logic open_wr;
   assign open_wr    = h_wr && !busy;
   assign cmd_accept = open_wr && (h_addr == A_CMD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         sptr_q   <= '0;
         dptr_q   <= '0;
         doorbell <= 1'b0;
      end else begin
         doorbell <= cmd_accept;
         if (cmd_accept) cmd_q <= h_wdata;
         if (open_wr && h_addr == A_SPTR) sptr_q <= h_wdata;
         if (open_wr && h_addr == A_DPTR) dptr_q <= h_wdata;
      end
   end

   for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_wb
      localparam logic [ADDR_W-1:0] A_W = ADDR_W'(OFF_WBUF + 4*gi);
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= '0;
         else if (open_wr && h_addr == A_W) word_q <= h_wdata;
      end
      assign wbuf_flat[gi*WORD_W +: WORD_W] = word_q;
   end

   // R4
   busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && h_wr && h_addr == A_CMD) |=> ($stable(cmd_q) && !doorbell));
   // R5
   busy_buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(wbuf_flat) && $stable(sptr_q) && $stable(dptr_q)));
endmodule

// File: rtl/mbx_status.sv
module mbx_status
   import mbx_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_accept,
   input  logic              doorbell,
   input  logic              irq_req,
   input  logic              sts_wr,
   input  logic              ack_bit,
   input  logic              ctl_done,
   input  logic              ctl_err,
   input  logic [CODE_W-1:0] ctl_code,
   output logic              busy,
   output logic              err,
   output logic [CODE_W-1:0] code,
   output logic              irq_flag,
   output logic              complete
);
   assign complete = ctl_done && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         err      <= 1'b0;
         code     <= '0;
         irq_flag <= 1'b0;
      end else begin
         if (cmd_accept) begin
            busy <= 1'b1;
            err  <= 1'b0;
            code <= '0;
         end else if (complete) begin
            busy <= 1'b0;
            err  <= ctl_err;
            code <= ctl_err ? ctl_code : '0;
         end
         if (complete && irq_req)   irq_flag <= 1'b1;
         else if (sts_wr && ack_bit) irq_flag <= 1'b0;
      end
   end

   // R2
   doorbell_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell |-> (busy && !err));
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ctl_done) |=> busy);
   // R7
   code_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err |-> (code == '0));
   // R8
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_accept && ctl_done) |=> ($stable(err) && $stable(code) && !busy));
   // R9
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && irq_req) |=> irq_flag);
endmodule

// File: rtl/mbx_rdbuf.sv
module mbx_rdbuf
   import mbx_pkg::*;
#(
   parameter int BUF_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IDX_W-1:0]            idx,
   input  logic [WORD_W-1:0]           data,
   input  logic                        commit,
   output logic [BUF_WORDS*WORD_W-1:0] rbuf_flat
);
   for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_rb
      logic [WORD_W-1:0] stage_q;
      logic [WORD_W-1:0] shown_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q <= '0;
            shown_q <= '0;
         end else begin
            if (we && idx == IDX_W'(gi)) stage_q <= data;
            if (commit) shown_q <= stage_q;
         end
      end
      assign rbuf_flat[gi*WORD_W +: WORD_W] = shown_q;
   end

   // R6
   shown_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(rbuf_flat));
endmodule

// File: rtl/host_ctl_mailbox.sv
module host_ctl_mailbox
   import mbx_pkg::*;
#(
   parameter int BUF_WORDS = 4,
   parameter int ADDR_W    = 8,
   parameter int SUB_W     = 4,
   parameter int LEN_W     = 5,
   parameter int CODE_W    = 8,
   localparam int IDX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
   localparam int BUF_W    = BUF_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [WORD_W-1:0] h_wdata,
   output logic [WORD_W-1:0] h_rdata,
   output logic              host_irq,
   output logic              ctl_doorbell,
   output logic [7:0]        ctl_op,
   output logic [SUB_W-1:0]  ctl_sub,
   output logic [LEN_W-1:0]  ctl_len,
   output logic              ctl_irq_req,
   output logic [WORD_W-1:0] ctl_sptr,
   output logic [WORD_W-1:0] ctl_dptr,
   output logic [BUF_W-1:0]  ctl_wbuf,
   input  logic              ctl_rb_we,
   input  logic [IDX_W-1:0]  ctl_rb_idx,
   input  logic [WORD_W-1:0] ctl_rb_data,
   input  logic              ctl_done,
   input  logic              ctl_err,
   input  logic [CODE_W-1:0] ctl_err_code
);
   if (BUF_WORDS < 1 || BUF_WORDS > MAX_WORDS) begin : g_bad_words
      initial $fatal(1, "BUF_WORDS must lie in 1..4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      initial $fatal(1, "ADDR_W must be at least 8");
   end
   if (SUB_W < 1 || SUB_W > CMD_LEN_LSB - CMD_SUB_LSB) begin : g_bad_sub
      initial $fatal(1, "SUB_W does not fit its field");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      initial $fatal(1, "LEN_W does not fit its field");
   end
   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
      initial $fatal(1, "CODE_W does not fit status bits 23:16");
   end

   logic              busy, err, irq_flag, complete, cmd_accept;
   logic [CODE_W-1:0] code;
   logic [WORD_W-1:0] cmd_q;
   logic [BUF_W-1:0]  rbuf_flat;
   logic              sts_wr;

   assign sts_wr = h_wr && (h_addr == ADDR_W'(OFF_STS));

   mbx_hostregs #(.BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
      .busy(busy), .cmd_accept(cmd_accept), .doorbell(ctl_doorbell),
      .cmd_q(cmd_q), .sptr_q(ctl_sptr), .dptr_q(ctl_dptr), .wbuf_flat(ctl_wbuf)
   );

   mbx_status #(.CODE_W(CODE_W)) u_sts (
      .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .doorbell(ctl_doorbell),
      .irq_req(cmd_q[CMD_IRQ_BIT]), .sts_wr(sts_wr), .ack_bit(h_wdata[ST_IRQ]),
      .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_code(ctl_err_code),
      .busy(busy), .err(err), .code(code), .irq_flag(irq_flag), .complete(complete)
   );

   mbx_rdbuf #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_rb (
      .clk(clk), .rst_n(rst_n), .we(ctl_rb_we), .idx(ctl_rb_idx), .data(ctl_rb_data),
      .commit(complete), .rbuf_flat(rbuf_flat)
   );

   assign ctl_op      = cmd_q[CMD_OP_W-1:0];
   assign ctl_irq_req = cmd_q[CMD_IRQ_BIT];
   assign ctl_sub     = cmd_q[CMD_SUB_LSB +: SUB_W];
   assign ctl_len     = cmd_q[CMD_LEN_LSB +: LEN_W];
   assign host_irq    = irq_flag;

   logic [WORD_W-1:0] sts_word;
   always_comb begin
      sts_word                         = '0;
      sts_word[ST_BUSY]                = busy;
      sts_word[ST_ERR]                 = err;
      sts_word[ST_IRQ]                 = irq_flag;
      sts_word[ST_CODE_LSB +: CODE_W]  = code;
   end

   always_comb begin
      h_rdata = '0;
      if (h_rd) begin
         if (h_addr == ADDR_W'(OFF_CMD))  h_rdata = cmd_q;
         if (h_addr == ADDR_W'(OFF_STS))  h_rdata = sts_word;
         if (h_addr == ADDR_W'(OFF_SPTR)) h_rdata = ctl_sptr;
         if (h_addr == ADDR_W'(OFF_DPTR)) h_rdata = ctl_dptr;
         for (int i = 0; i < BUF_WORDS; i++) begin
            if (h_addr == ADDR_W'(OFF_WBUF + 4*i)) h_rdata = ctl_wbuf[i*WORD_W +: WORD_W];
            if (h_addr == ADDR_W'(OFF_RBUF + 4*i)) h_rdata = rbuf_flat[i*WORD_W +: WORD_W];
         end
      end
   end

   // R9
   irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && h_wdata[ST_IRQ] && !complete) |=> !host_irq);
   // R1
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !h_rd |-> (h_rdata == '0));
endmodule

// File: tb/test_host_ctl_mailbox.sv
module test_host_ctl_mailbox;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [7:0]   h_addr;
   logic         h_wr, h_rd;
   logic [31:0]  h_wdata, h_rdata;
   logic         host_irq, ctl_doorbell, ctl_irq_req;
   logic [7:0]   ctl_op;
   logic [3:0]   ctl_sub;
   logic [4:0]   ctl_len;
   logic [31:0]  ctl_sptr, ctl_dptr;
   logic [127:0] ctl_wbuf;
   logic         ctl_rb_we, ctl_done, ctl_err;
   logic [1:0]   ctl_rb_idx;
   logic [31:0]  ctl_rb_data;
   logic [7:0]   ctl_err_code;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   host_ctl_mailbox i_host_ctl_mailbox (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
      .ctl_doorbell(ctl_doorbell), .ctl_op(ctl_op), .ctl_sub(ctl_sub),
      .ctl_len(ctl_len), .ctl_irq_req(ctl_irq_req), .ctl_sptr(ctl_sptr),
      .ctl_dptr(ctl_dptr), .ctl_wbuf(ctl_wbuf), .ctl_rb_we(ctl_rb_we),
      .ctl_rb_idx(ctl_rb_idx), .ctl_rb_data(ctl_rb_data), .ctl_done(ctl_done),
      .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected read value pushed by the driver
   always @(negedge clk) begin
      if (h_rd) begin
         tests++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1: unexpected read, actual %h expected none", h_rdata);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (h_rdata !== e) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", t, h_rdata, e);
            end
         end
      end
   end

   task automatic hw(input logic [7:0] a, input logic [31:0] d);
      h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(posedge clk); #1;
      h_wr = 1'b0;
   endtask

   task automatic hr(input logic [7:0] a, input logic [31:0] e, input string tag);
      h_addr = a; h_rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      h_rd = 1'b0;
   endtask

   task automatic stage(input logic [1:0] i, input logic [31:0] d);
      ctl_rb_idx = i; ctl_rb_data = d; ctl_rb_we = 1'b1;
      @(posedge clk); #1;
      ctl_rb_we = 1'b0;
   endtask

   task automatic finish_cmd(input logic e, input logic [7:0] c);
      ctl_err = e; ctl_err_code = c; ctl_done = 1'b1;
      @(posedge clk); #1;
      ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; h_addr = '0; h_wr = 0; h_rd = 0; h_wdata = '0;
      ctl_rb_we = 0; ctl_rb_idx = '0; ctl_rb_data = '0;
      ctl_done = 0; ctl_err = 0; ctl_err_code = '0;
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;

      // R10 reset state
      hr(8'h04, 32'h0, "R10 status");
      hr(8'h00, 32'h0, "R10 command");
      hr(8'h9C, 32'h0, "R10 inbound word3");
      chk("R10 irq", {31'b0, host_irq}, 32'h0);
      chk("R10 doorbell", {31'b0, ctl_doorbell}, 32'h0);

      // R1 pointers and outbound area
      hw(8'h08, 32'h1111_AAAA);
      hw(8'h0C, 32'h2222_BBBB);
      for (int i = 0; i < 4; i++) hw(8'h80 + 8'(4*i), 32'hC0DE_0000 + 32'(i));
      hr(8'h08, 32'h1111_AAAA, "R1 sptr");
      hr(8'h0C, 32'h2222_BBBB, "R1 dptr");
      hr(8'h8C, 32'hC0DE_0003, "R1 outbound word3");
      hr(8'h40, 32'h0, "R1 unmapped");
      chk("R1 ctl_wbuf word0", ctl_wbuf[31:0], 32'hC0DE_0000);

      // R2/R3 command accept
      hw(8'h00, 32'h0008_513A);
      chk("R2 doorbell pulse", {31'b0, ctl_doorbell}, 32'h1);
      chk("R3 op", {24'b0, ctl_op}, 32'h3A);
      chk("R3 sub", {28'b0, ctl_sub}, 32'h5);
      chk("R3 len", {27'b0, ctl_len}, 32'h8);
      chk("R3 irq req", {31'b0, ctl_irq_req}, 32'h1);
      @(posedge clk); #1;
      chk("R2 doorbell single", {31'b0, ctl_doorbell}, 32'h0);
      hr(8'h04, 32'h1, "R2 busy");

      // R4 command while busy
      hw(8'h00, 32'h0000_0077);
      chk("R4 no doorbell", {31'b0, ctl_doorbell}, 32'h0);
      hr(8'h00, 32'h0008_513A, "R4 command kept");

      // R5 blocked writes
      hw(8'h80, 32'hDEAD_BEEF);
      hw(8'h08, 32'h5555_5555);
      chk("R5 outbound blocked", ctl_wbuf[31:0], 32'hC0DE_0000);
      hr(8'h08, 32'h1111_AAAA, "R5 sptr blocked");

      // R6 staging invisible while busy
      for (int i = 0; i < 4; i++) stage(2'(i), 32'hF00D_0010 + 32'(i));
      hr(8'h90, 32'h0, "R6 inbound old while busy");

      // R7/R9 completion without error
      finish_cmd(1'b0, 8'h05);
      hr(8'h04, 32'h4, "R7 status after done");
      chk("R9 irq raised", {31'b0, host_irq}, 32'h1);
      for (int i = 0; i < 4; i++) hr(8'h90 + 8'(4*i), 32'hF00D_0010 + 32'(i), "R6 inbound committed");

      // R9 ack with 0 leaves, with 1 clears; RO bits untouched
      hw(8'h04, 32'h0000_0003);
      chk("R9 ack zero keeps", {31'b0, host_irq}, 32'h1);
      hw(8'h04, 32'h0000_0004);
      chk("R9 ack clears", {31'b0, host_irq}, 32'h0);
      hr(8'h04, 32'h0, "R9 status after ack");

      // R7 error completion, no interrupt requested
      hw(8'h00, 32'h0000_2011);
      finish_cmd(1'b1, 8'h06);
      hr(8'h04, 32'h0006_0002, "R7 error code 6");
      chk("R9 no irq when not requested", {31'b0, host_irq}, 32'h0);

      // R8 done while idle
      finish_cmd(1'b1, 8'h03);
      hr(8'h04, 32'h0006_0002, "R8 idle done ignored");
      hr(8'h90, 32'hF00D_0010, "R8 inbound kept");

      // R2 new command clears error; R7 code 7 then clean finish
      hw(8'h00, 32'h0010_0001);
      hr(8'h04, 32'h1, "R2 error cleared");
      chk("R3 len 16", {27'b0, ctl_len}, 32'h10);
      finish_cmd(1'b1, 8'h07);
      hr(8'h04, 32'h0007_0002, "R7 error code 7");
      hw(8'h00, 32'h0000_0002);
      finish_cmd(1'b0, 8'h07);
      hr(8'h04, 32'h0, "R7 code zero without error");

      @(posedge clk); #1;
      chk("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule